// File: doc/BRIEF.md
# Brown-out Reset Sequencing Controller

This block decides when a small processor core is held in reset after the supply sags. An external comparator supplies a synchronous, single-bit low-supply flag. The block gates that flag with a two-bit mode field, a software enable register and a sleep indication. It keeps the reset off until the flag has stayed low for a minimum run of cycles. It then holds the reset for as long as the flag stays asserted. When the power-up timer is enabled, it extends the reset by a fixed number of cycles after the supply recovers.

Two status flags can be read by software and set by a write strobe: a power-on flag and a brown-out flag. The power-on reset input clears both flags. Each entry into the held state clears only the brown-out flag. Software can therefore read "brown-out flag 0, power-on flag 1" as evidence of a brown-out.

The sequencer has four states:
- `ST_RUN` is idle, with the reset released.
- `ST_QUAL` is qualifying a dip, with the reset still released.
- `ST_HOLD` is brown-out reset held.
- `ST_PWRT` is the power-up delay running, with the reset still held.

It has these transitions:
- RUN→QUAL on a low sample while detection is on.
- QUAL→RUN when the dip ends or detection turns off.
- QUAL→HOLD on the qualifying sample.
- HOLD→PWRT on recovery with the timer enabled.
- HOLD→RUN on recovery with the timer disabled, or when detection turns off.
- PWRT→HOLD on a new dip while detection is on.
- PWRT→RUN when the delay expires.

Top module: `bor_seq_ctrl`

## Requirements
- R1: With `mode_cfg` = 2'b00, detection is off: a low-supply run of any length, under any software enable or sleep value, never raises `core_rst`.
- R2: With `mode_cfg` = 2'b01, detection is on only while the software enable register is 1. The register is loaded from `sw_en_wdata` on a `sw_en_wr` strobe and resets to 1 on power-on reset.
- R3: `sw_en_rd` returns the software enable register when `mode_cfg` = 2'b01 and returns 0 in every other mode.
- R4: With `mode_cfg` = 2'b10, detection is on while `sleep` is 0 and off while `sleep` is 1.
- R5: With `mode_cfg` = 2'b11, detection is always on, whatever the values of the software enable and `sleep`.
- R6: With detection on, `core_rst` rises just after the clock edge that samples the QUAL_CYC-th consecutive `supply_low` = 1. A shorter run leaves `core_rst` at 0 and leaves `bor_flag` unchanged.
- R7: Once raised, `core_rst` stays 1 for as long as `supply_low` is 1 and detection is on.
- R8: With `pwrt_en` = 1, `core_rst` stays 1 for PWRT_CYC more cycles after the first edge that samples `supply_low` = 0, then falls. With `pwrt_en` = 0, it falls at that first edge. The timer and detection are enabled independently.
- R9: A `supply_low` = 1 sample during the power-up delay, with detection on, returns the block to held reset at once. The full delay then restarts after the next recovery.
- R10: Every entry into held reset clears `bor_flag` and leaves `por_flag` unchanged.
- R11: `por_n` low asynchronously clears both flags and releases `core_rst`. A `flag_set` strobe sets the flags it names, with bit 0 for `por_flag` and bit 1 for `bor_flag`. A clear from entering held reset wins over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| supply_low | input | 1 | Synchronous low-supply indication from the comparator |
| mode_cfg | input | 2 | Detection mode: 00 off, 01 software-gated, 10 off in sleep, 11 always on |
| sleep | input | 1 | Sleep-mode indication |
| pwrt_en | input | 1 | Power-up timer enable |
| sw_en_wr | input | 1 | Write strobe for the software enable register |
| sw_en_wdata | input | 1 | Value loaded into the software enable register |
| flag_set | input | 2 | Set strobes: bit 0 sets por_flag, bit 1 sets bor_flag |
| core_rst | output | 1 | Core reset request, active high |
| sw_en_rd | output | 1 | Software enable readback |
| por_flag | output | 1 | Power-on status flag |
| bor_flag | output | 1 | Brown-out status flag |

## Verification
The bench builds the block with QUAL_CYC = 3 and PWRT_CYC = 5. These small values let it sweep every mode, software enable and sleep combination. For each combination it applies one dip one cycle shorter than the qualification length and one dip of exactly that length.

The short delay also lets the bench count every cycle of the power-up window. It can time a dip injected in the middle of the window, then the full restart, and check the flag clear-versus-set priority on the qualifying edge.

// File: rtl/bor_pkg.sv
package bor_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_QUAL = 2'd1,
        ST_HOLD = 2'd2,
        ST_PWRT = 2'd3
    } bor_state_e;

    localparam logic [1:0] MODE_OFF   = 2'b00;
    localparam logic [1:0] MODE_SOFT  = 2'b01;
    localparam logic [1:0] MODE_NOSLP = 2'b10;
    localparam logic [1:0] MODE_ON    = 2'b11;
endpackage

// File: rtl/bor_mode_gate.sv
module bor_mode_gate
    import bor_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic [1:0] mode_cfg,
    input  logic       sleep,
    input  logic       sw_en_wr,
    input  logic       sw_en_wdata,
    output logic       det_on,
    output logic       sw_en_rd
);
    logic sw_en_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        sw_en_q <= 1'b1;
        else if (sw_en_wr) sw_en_q <= sw_en_wdata;
    end

    always_comb begin
        unique case (mode_cfg)
            MODE_OFF:   det_on = 1'b0;
            MODE_SOFT:  det_on = sw_en_q;
            MODE_NOSLP: det_on = ~sleep;
            MODE_ON:    det_on = 1'b1;
            default:    det_on = 1'b0;
        endcase
        sw_en_rd = (mode_cfg == MODE_SOFT) ? sw_en_q : 1'b0;
    end
endmodule

// File: rtl/bor_delay_cnt.sv
module bor_delay_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)   cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
        else          cnt <= '0;
    end
endmodule

// File: rtl/bor_status_flags.sv
module bor_status_flags (
    input  logic       clk,
    input  logic       por_n,
    input  logic       bo_evt,
    input  logic [1:0] flag_set,
    output logic       por_flag,
    output logic       bor_flag
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            por_flag <= 1'b0;
            bor_flag <= 1'b0;
        end else begin
            if (flag_set[0]) por_flag <= 1'b1;
            if (bo_evt)           bor_flag <= 1'b0;
            else if (flag_set[1]) bor_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/bor_seq_ctrl.sv
module bor_seq_ctrl
    import bor_pkg::*;
#(
    parameter int QUAL_CYC = 4,
    parameter int PWRT_CYC = 64
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       supply_low,
    input  logic [1:0] mode_cfg,
    input  logic       sleep,
    input  logic       pwrt_en,
    input  logic       sw_en_wr,
    input  logic       sw_en_wdata,
    input  logic [1:0] flag_set,
    output logic       core_rst,
    output logic       sw_en_rd,
    output logic       por_flag,
    output logic       bor_flag
);
    localparam int CMAX = (QUAL_CYC > PWRT_CYC) ? QUAL_CYC : PWRT_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] QUAL_LAST = CW'(QUAL_CYC - 2);
    localparam logic [CW-1:0] PWRT_LAST = CW'(PWRT_CYC - 1);

    bor_state_e    state_q, state_d;
    logic          det_on;
    logic          cnt_inc;
    logic          bo_evt;
    logic [CW-1:0] cnt;

    initial begin
        if (QUAL_CYC < 2) $error("QUAL_CYC must be at least 2");
        if (PWRT_CYC < 1) $error("PWRT_CYC must be at least 1");
    end

    bor_mode_gate u_gate (
        .clk         (clk),
        .por_n       (por_n),
        .mode_cfg    (mode_cfg),
        .sleep       (sleep),
        .sw_en_wr    (sw_en_wr),
        .sw_en_wdata (sw_en_wdata),
        .det_on      (det_on),
        .sw_en_rd    (sw_en_rd)
    );

    bor_delay_cnt #(.W(CW)) u_cnt (
        .clk   (clk),
        .por_n (por_n),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    bor_status_flags u_flags (
        .clk      (clk),
        .por_n    (por_n),
        .bo_evt   (bo_evt),
        .flag_set (flag_set),
        .por_flag (por_flag),
        .bor_flag (bor_flag)
    );

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:
                if (det_on && supply_low) state_d = ST_QUAL;
            ST_QUAL:
                if (!det_on || !supply_low) state_d = ST_RUN;
                else if (cnt == QUAL_LAST)  state_d = ST_HOLD;
            ST_HOLD:
                if (!det_on)        state_d = ST_RUN;
                else if (!supply_low) state_d = pwrt_en ? ST_PWRT : ST_RUN;
            ST_PWRT:
                if (det_on && supply_low)  state_d = ST_HOLD;
                else if (cnt == PWRT_LAST) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // Outputs and controls
    always_comb begin
        core_rst = 1'b0;
        cnt_inc  = 1'b0;
        unique case (state_q)
            ST_RUN:  ;
            ST_QUAL: cnt_inc = 1'b1;
            ST_HOLD: core_rst = 1'b1;
            ST_PWRT: begin
                core_rst = 1'b1;
                cnt_inc  = 1'b1;
            end
            default: ;
        endcase
        bo_evt = (state_d == ST_HOLD) && (state_q != ST_HOLD);
    end
endmodule

// File: rtl/bor_seq_ctrl_chk.sv
module bor_seq_ctrl_chk (
    input logic       clk,
    input logic       por_n,
    input logic       supply_low,
    input logic [1:0] mode_cfg,
    input logic       core_rst,
    input logic       sw_en_rd,
    input logic       por_flag,
    input logic       bor_flag
);
    // R1
    mode_off_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode_cfg == 2'b00 && !core_rst) |=> !core_rst);

    // R3
    swen_readback_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode_cfg != 2'b01) |-> !sw_en_rd);

    // R6
    rise_needs_low_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(core_rst) |-> $past(supply_low));

    // R7
    hold_while_low_chk: assert property (@(posedge clk) disable iff (!por_n)
        (core_rst && supply_low && mode_cfg == 2'b11) |=> core_rst);

    // R10
    bor_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(core_rst) |-> (!bor_flag && $stable(por_flag)));
endmodule

bind bor_seq_ctrl bor_seq_ctrl_chk u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .supply_low (supply_low),
    .mode_cfg   (mode_cfg),
    .core_rst   (core_rst),
    .sw_en_rd   (sw_en_rd),
    .por_flag   (por_flag),
    .bor_flag   (bor_flag)
);

// File: tb/bor_seq_ctrl_tb.sv
`timescale 1ns/1ps
module bor_seq_ctrl_tb;
    localparam int QC = 3;
    localparam int PC = 5;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       supply_low = 1'b0;
    logic [1:0] mode_cfg = 2'b11;
    logic       sleep = 1'b0;
    logic       pwrt_en = 1'b0;
    logic       sw_en_wr = 1'b0;
    logic       sw_en_wdata = 1'b0;
    logic [1:0] flag_set = 2'b00;
    logic       core_rst, sw_en_rd, por_flag, bor_flag;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bor_seq_ctrl #(.QUAL_CYC(QC), .PWRT_CYC(PC)) u_dut (
        .clk(clk), .por_n(por_n), .supply_low(supply_low), .mode_cfg(mode_cfg),
        .sleep(sleep), .pwrt_en(pwrt_en), .sw_en_wr(sw_en_wr),
        .sw_en_wdata(sw_en_wdata), .flag_set(flag_set), .core_rst(core_rst),
        .sw_en_rd(sw_en_rd), .por_flag(por_flag), .bor_flag(bor_flag)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int det_exp(input int m, input int s, input int sl);
        case (m)
            0: return 0;
            1: return s;
            2: return (sl == 0) ? 1 : 0;
            default: return 1;
        endcase
    endfunction

    task automatic set_flags(input logic [1:0] v);
        flag_set = v;
        tick();
        flag_set = 2'b00;
    endtask

    task automatic enter_hold();
        supply_low = 1'b1;
        for (int i = 0; i < QC; i++) tick();
    endtask

    task automatic release_and_time(input string tag);
        supply_low = 1'b0;
        for (int i = 1; i <= PC; i++) begin
            tick();
            check(tag, core_rst, 1);
        end
        tick();
        check(tag, core_rst, 0);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #35;
        check("reset R11 core_rst", core_rst, 0);
        check("reset R11 por_flag", por_flag, 0);
        check("reset R11 bor_flag", bor_flag, 0);
        por_n = 1'b1;
        mode_cfg = 2'b01;
        tick();
        check("R2 sw enable resets to 1", sw_en_rd, 1);

        // Sweep modes, software enable, sleep (R1..R6, R10, R8 no-timer)
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                for (int sl = 0; sl < 2; sl++) begin
                    int act;
                    string tg;
                    act = det_exp(m, s, sl);
                    tg = (m == 0) ? "R1" : (m == 1) ? "R2" : (m == 2) ? "R4" : "R5";
                    mode_cfg = m[1:0];
                    sleep = sl[0];
                    pwrt_en = 1'b0;
                    sw_en_wr = 1'b1;
                    sw_en_wdata = s[0];
                    tick();
                    sw_en_wr = 1'b0;
                    check("R3 sw_en_rd", sw_en_rd, (m == 1) ? s : 0);
                    set_flags(2'b11);
                    supply_low = 1'b1;
                    for (int i = 0; i < QC - 1; i++) begin
                        tick();
                        check("R6 short dip no reset", core_rst, 0);
                    end
                    supply_low = 1'b0;
                    tick();
                    check("R6 short dip keeps bor_flag", bor_flag, 1);
                    supply_low = 1'b1;
                    for (int i = 0; i < QC - 1; i++) tick();
                    check({tg, " R6 before qualifying edge"}, core_rst, 0);
                    tick();
                    check({tg, " R6 qualified dip"}, core_rst, act);
                    check("R10 bor_flag after dip", bor_flag, (act != 0) ? 0 : 1);
                    check("R10 por_flag kept", por_flag, 1);
                    supply_low = 1'b0;
                    tick();
                    check("R8 no timer release", core_rst, 0);
                end
            end
        end

        // R7 hold while low
        mode_cfg = 2'b11;
        sleep = 1'b1;
        enter_hold();
        for (int i = 0; i < 12; i++) begin
            tick();
            check("R7 held while low", core_rst, 1);
        end

        // R8 power-up delay timing
        pwrt_en = 1'b1;
        release_and_time("R8 power-up delay");

        // R9 dip during delay restarts
        enter_hold();
        supply_low = 1'b0;
        for (int i = 0; i < 3; i++) tick();
        check("R9 in delay", core_rst, 1);
        supply_low = 1'b1;
        tick();
        check("R9 re-held", core_rst, 1);
        release_and_time("R9 restarted delay");

        // R11 clear wins over set on qualifying edge
        set_flags(2'b11);
        supply_low = 1'b1;
        for (int i = 0; i < QC - 1; i++) tick();
        flag_set = 2'b10;
        tick();
        flag_set = 2'b00;
        check("R11 clear wins core_rst", core_rst, 1);
        check("R11 clear wins bor_flag", bor_flag, 0);
        set_flags(2'b10);
        check("R11 set bor_flag", bor_flag, 1);

        // R11 asynchronous power-on reset in held state
        #5;
        por_n = 1'b0;
        #3;
        check("R11 por clears por_flag", por_flag, 0);
        check("R11 por clears bor_flag", bor_flag, 0);
        check("R11 por releases core_rst", core_rst, 0);
        supply_low = 1'b0;
        mode_cfg = 2'b01;
        #20;
        por_n = 1'b1;
        tick();
        check("R2 sw enable back to 1 after por", sw_en_rd, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule